// File: doc/BRIEF.md
# Scalar Double-Precision Maximum/Minimum Unit

This block returns the larger or the smaller of two IEEE-754 binary64 operands. Its result is fully determined for every input pair. A NaN operand is passed through unchanged, with operand A taking precedence. Two zeros of opposite sign are ordered by the selected operation. The ordering is worked out with plain integer logic on the sign-magnitude encoding, and no floating-point datapath is involved.

The unit sits in an execution pipeline behind instruction decode. Each operation presents both operands, a max/min select and the current invalid-trap enable with an input strobe. One cycle later the unit delivers the result, a write-enable for the destination register and a flag that reports a signaling NaN. When that flag is raised and the trap is enabled, the write-enable is dropped so that the destination keeps its old value. The flag is still reported in that case, so the surrounding logic can record it.

Top module: `fp_maxmin_unit`

## Requirements
- R1: When A is a NaN (exponent bits 62:52 all ones and fraction bits 51:0 nonzero), the result is A bit-for-bit, with its payload kept and not quieted, whatever B holds.
- R2: When A is not a NaN and B is a NaN, the result is B bit-for-bit.
- R3: `snan_flag` is 1 only when the returned NaN is signaling, meaning fraction bit 51 is 0. A signaling B that sits behind a quiet NaN in A leaves the flag at 0.
- R4: In max mode (`sel_max`=1) with both operands zero, the result is +0 (all bits 0) unless both operands are -0. In that case the result is -0 (0x8000000000000000).
- R5: In min mode (`sel_max`=0) with both operands zero, the result is -0 when either operand is -0, and +0 otherwise.
- R6: In max mode, with no NaN and not both zero, the result is A when A is not less than B, and B otherwise. Equal operands therefore give A.
- R7: In min mode, with no NaN and not both zero, the result is A only when A is strictly less than B, and B otherwise.
- R8: The ordering is sign-magnitude. Among positives the larger magnitude is greater, among negatives the larger magnitude is smaller, and any negative is below any positive. Infinities and subnormals are ordered as they are encoded, with no flushing.
- R9: When `snan_flag` is 1 and `trap_en` was 1 with the operation, `wr_en` is 0. In every other case a valid result has `wr_en` at 1.
- R10: `out_valid` follows `in_valid` with one cycle of latency. While `out_valid` is 0, `wr_en` and `snan_flag` are 0 and `result` holds its last value.
- R11: After reset, `out_valid`, `wr_en` and `snan_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 64 | Operand A, binary64 |
| op_b | input | 64 | Operand B, binary64 |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| trap_en | input | 1 | Invalid-operation trap enable |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Selected value |
| wr_en | output | 1 | Write the result to the destination |
| snan_flag | output | 1 | Returned NaN is signaling |

## Verification
The bench builds the unit with its default binary64 format: an 11-bit exponent and a 52-bit fraction. This makes literal encodings usable as stimulus. These include both infinities, both zeros, the smallest subnormal, the largest normal, and NaNs that carry distinctive payloads in the upper and lower fraction bits. The bench can therefore confirm that payloads pass through unchanged, and that the quiet bit at position 51 alone decides the flag. With this width the sign-magnitude ordering is exercised across the full 63-bit magnitude, including the boundary between the largest finite value and infinity.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  // Properties of one operand, derived from its encoding
  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic sign;
  } fpmm_class_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output fpmm_class_t  cls
);

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign expo = val[W-2:FRAC_W];
  assign frac = val[FRAC_W-1:0];

  always_comb begin
    cls.sign = val[W-1];
    cls.nan  = (&expo) && (|frac);
    cls.snan = (&expo) && (|frac) && !frac[FRAC_W-1];
    cls.zero = (~|expo) && (~|frac);
  end

endmodule

// File: rtl/fpmm_less.sv
module fpmm_less #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_lt_b
);

  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;

  assign mag_a = a[W-2:0];
  assign mag_b = b[W-2:0];

  // Sign-magnitude ordering; the both-zero case is resolved elsewhere
  always_comb begin
    if (a[W-1] != b[W-1]) begin
      a_lt_b = a[W-1];
    end else if (!a[W-1]) begin
      a_lt_b = (mag_a < mag_b);
    end else begin
      a_lt_b = (mag_a > mag_b);
    end
  end

endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fpmm_class_t  cls_a,
  input  fpmm_class_t  cls_b,
  input  logic         a_lt_b,
  input  logic         sel_max,
  output logic [W-1:0] res,
  output logic         snan
);

  localparam logic [W-1:0] POS_ZERO = '0;
  localparam logic [W-1:0] NEG_ZERO = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    snan = 1'b0;
    if (cls_a.nan) begin
      res  = a;
      snan = cls_a.snan;
    end else if (cls_b.nan) begin
      res  = b;
      snan = cls_b.snan;
    end else if (cls_a.zero && cls_b.zero) begin
      if (sel_max) begin
        res = (cls_a.sign && cls_b.sign) ? NEG_ZERO : POS_ZERO;
      end else begin
        res = (cls_a.sign || cls_b.sign) ? NEG_ZERO : POS_ZERO;
      end
    end else if (sel_max ? !a_lt_b : a_lt_b) begin
      res = a;
    end else begin
      res = b;
    end
  end

endmodule

// File: rtl/fp_maxmin_unit.sv
module fp_maxmin_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sel_max,
  input  logic         trap_en,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         snan_flag
);

  logic [W-1:0] opnd [2];
  fpmm_class_t  cls  [2];
  logic         a_lt_b;
  logic [W-1:0] pick_res;
  logic         pick_snan;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val (opnd[i]),
      .cls (cls[i])
    );
  end

  fpmm_less #(.W(W)) u_less (
    .a      (op_a),
    .b      (op_b),
    .a_lt_b (a_lt_b)
  );

  fpmm_pick #(.W(W)) u_pick (
    .a       (op_a),
    .b       (op_b),
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .a_lt_b  (a_lt_b),
    .sel_max (sel_max),
    .res     (pick_res),
    .snan    (pick_snan)
  );

  // Next state
  logic [W-1:0] res_d, res_q;
  logic         vld_d, vld_q;
  logic         flg_d, flg_q;
  logic         we_d,  we_q;

  always_comb begin
    res_d = in_valid ? pick_res : res_q;
    vld_d = in_valid;
    flg_d = in_valid && pick_snan;
    we_d  = in_valid && !(pick_snan && trap_en);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      flg_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
      flg_q <= flg_d;
      we_q  <= we_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign wr_en     = we_q;
  assign snan_flag = flg_q;

endmodule

// File: rtl/fp_maxmin_unit_chk.sv
module fp_maxmin_unit_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sel_max,
  input logic         trap_en,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         snan_flag
);

  logic a_is_nan, b_is_nan, res_is_snan;
  assign a_is_nan    = (&op_a[W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
  assign b_is_nan    = (&op_b[W-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);
  assign res_is_snan = (&result[W-2:FRAC_W]) && (|result[FRAC_W-1:0])
                       && !result[FRAC_W-1];

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !snan_flag));

  // R1
  a_nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_is_nan) |=> (result == $past(op_a)));

  // R2
  b_nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_is_nan && b_is_nan) |=> (result == $past(op_b)));

  // R3
  flag_needs_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snan_flag |-> res_is_snan);

  // R9
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && trap_en) |=> !(snan_flag && wr_en));

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R6
  max_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_max && !a_is_nan && !b_is_nan && (op_a == op_b))
      |=> (result == $past(op_a)));

endmodule

bind fp_maxmin_unit fp_maxmin_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .sel_max   (sel_max),
  .trap_en   (trap_en),
  .out_valid (out_valid),
  .result    (result),
  .wr_en     (wr_en),
  .snan_flag (snan_flag)
);

// File: tb/fp_maxmin_unit_bench.sv
`timescale 1ns/1ps
module fp_maxmin_unit_bench;

  localparam logic [63:0] PZ    = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] MAXN  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_1234;
  localparam logic [63:0] QNANN = 64'hFFF8_0000_DEAD_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0ABC;
  localparam logic [63:0] SNANN = 64'hFFF4_5A5A_0000_0003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_a, op_b;
  logic        sel_max, trap_en;
  logic        out_valid, wr_en, snan_flag;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fp_maxmin_unit u_fp_maxmin_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .sel_max   (sel_max),
    .trap_en   (trap_en),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .snan_flag (snan_flag)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one operation and check the registered outputs one cycle later
  task automatic op(input string req, input logic [63:0] a, input logic [63:0] b,
                    input logic mx, input logic trap, input logic [63:0] exp_res,
                    input logic exp_flag, input logic exp_we);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; sel_max = mx; trap_en = trap;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " result"}, result, exp_res);
    check({req, " flag"}, {63'd0, snan_flag}, {63'd0, exp_flag});
    check({req, " wr_en"}, {63'd0, wr_en}, {63'd0, exp_we});
  endtask

  task automatic t_reset;
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 wr_en", {63'd0, wr_en}, 64'd0);
    check("R11 snan_flag", {63'd0, snan_flag}, 64'd0);
  endtask

  task automatic t_a_nan;
    op("R1 qnan A vs one", QNAN, ONE, 1'b1, 1'b0, QNAN, 1'b0, 1'b1);
    op("R1 snan A vs qnan B", SNAN, QNAN, 1'b0, 1'b0, SNAN, 1'b1, 1'b1);
    op("R1 neg qnan A vs snan B", QNANN, SNAN, 1'b1, 1'b0, QNANN, 1'b0, 1'b1);
    op("R3 qnan A hides snan B", QNAN, SNANN, 1'b0, 1'b0, QNAN, 1'b0, 1'b1);
  endtask

  task automatic t_b_nan;
    op("R2 snan B", ONE, SNAN, 1'b1, 1'b0, SNAN, 1'b1, 1'b1);
    op("R2 neg qnan B vs -inf", NINF, QNANN, 1'b0, 1'b0, QNANN, 1'b0, 1'b1);
    op("R3 neg snan B payload", PINF, SNANN, 1'b1, 1'b0, SNANN, 1'b1, 1'b1);
  endtask

  task automatic t_zeros;
    op("R4 max +0,-0", PZ, NZ, 1'b1, 1'b0, PZ, 1'b0, 1'b1);
    op("R4 max -0,+0", NZ, PZ, 1'b1, 1'b0, PZ, 1'b0, 1'b1);
    op("R4 max -0,-0", NZ, NZ, 1'b1, 1'b0, NZ, 1'b0, 1'b1);
    op("R4 max +0,+0", PZ, PZ, 1'b1, 1'b0, PZ, 1'b0, 1'b1);
    op("R5 min +0,-0", PZ, NZ, 1'b0, 1'b0, NZ, 1'b0, 1'b1);
    op("R5 min -0,+0", NZ, PZ, 1'b0, 1'b0, NZ, 1'b0, 1'b1);
    op("R5 min +0,+0", PZ, PZ, 1'b0, 1'b0, PZ, 1'b0, 1'b1);
    op("R5 min -0,-0", NZ, NZ, 1'b0, 1'b0, NZ, 1'b0, 1'b1);
  endtask

  task automatic t_order;
    op("R6 max 1,2", ONE, TWO, 1'b1, 1'b0, TWO, 1'b0, 1'b1);
    op("R6 max 2,1", TWO, ONE, 1'b1, 1'b0, TWO, 1'b0, 1'b1);
    op("R6 max equal", MAXN, MAXN, 1'b1, 1'b0, MAXN, 1'b0, 1'b1);
    op("R7 min 1,2", ONE, TWO, 1'b0, 1'b0, ONE, 1'b0, 1'b1);
    op("R7 min equal", NTWO, NTWO, 1'b0, 1'b0, NTWO, 1'b0, 1'b1);
    op("R8 min -1,-2", NONE, NTWO, 1'b0, 1'b0, NTWO, 1'b0, 1'b1);
    op("R8 max -1,-2", NONE, NTWO, 1'b1, 1'b0, NONE, 1'b0, 1'b1);
    op("R8 max -inf,+inf", NINF, PINF, 1'b1, 1'b0, PINF, 1'b0, 1'b1);
    op("R8 min -inf,+inf", NINF, PINF, 1'b0, 1'b0, NINF, 1'b0, 1'b1);
    op("R8 max maxnorm,+inf", MAXN, PINF, 1'b1, 1'b0, PINF, 1'b0, 1'b1);
    op("R8 min subnormal,+0", SUBN, PZ, 1'b0, 1'b0, PZ, 1'b0, 1'b1);
    op("R8 max -0,subnormal", NZ, SUBN, 1'b1, 1'b0, SUBN, 1'b0, 1'b1);
    op("R8 min -1,subnormal", NONE, SUBN, 1'b0, 1'b0, NONE, 1'b0, 1'b1);
  endtask

  task automatic t_trap;
    op("R9 snan A trapped", SNAN, ONE, 1'b1, 1'b1, SNAN, 1'b1, 1'b0);
    op("R9 snan B trapped", TWO, SNANN, 1'b0, 1'b1, SNANN, 1'b1, 1'b0);
    op("R9 qnan trap enabled", QNAN, ONE, 1'b0, 1'b1, QNAN, 1'b0, 1'b1);
    op("R9 numbers trap enabled", ONE, TWO, 1'b0, 1'b1, ONE, 1'b0, 1'b1);
  endtask

  task automatic t_idle;
    op("R10 before idle", SNAN, PZ, 1'b1, 1'b0, SNAN, 1'b1, 1'b1);
    @(negedge clk);
    op_a = TWO; op_b = ONE; sel_max = 1'b1;
    @(negedge clk);
    check("R10 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 idle wr_en", {63'd0, wr_en}, 64'd0);
    check("R10 idle snan_flag", {63'd0, snan_flag}, 64'd0);
    check("R10 idle result held", result, SNAN);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    sel_max = 1'b0; trap_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a_nan();
    t_b_nan();
    t_zeros();
    t_order();
    t_trap();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule